// File: doc/BRIEF.md
# Inter-core flag and semaphore registers

This block is a small register file that lets two processor cores signal each other. Each core has its own single-cycle register port. A core raises flags by writing ones to the set register. The flags are then cleared through either of two registers, clear or acknowledge. Both cores can read the status register. The lowest flags also drive interrupt lines toward the receiving core, and each line stays high for as long as its flag is set.

The block also holds a two-bit ownership semaphore. A write to the semaphore register takes effect only when the upper 28 bits of the written word carry a fixed key. Any other write to that register is dropped. This protects the semaphore from stray writes.

Register map, by byte offset on the 5-bit address:

| Offset | Register |
|--------|----------|
| 0x00 | status |
| 0x04 | set |
| 0x08 | clear |
| 0x0C | acknowledge |
| 0x10 | semaphore |

Writes update state at the next rising clock edge. Read data is combinational from the current state.

Top module: `ipc_mailbox_regs`

## Requirements
- R1: After reset the status register reads 0, the semaphore reads 0 and all interrupt lines are low.
- R2: A write to offset 0x04 sets every status bit whose data bit is 1, from the next rising edge on. Data bits that are 0 leave their flags unchanged.
- R3: A write to offset 0x08 clears every status bit whose data bit is 1. All other flags are left as they are.
- R4: A write to offset 0x0C clears flags in the same way as offset 0x08.
- R5: If a set and a clear or acknowledge reach the same flag in the same cycle, from either port, the flag ends up 0.
- R6: The status register holds 12 flags in bits 11:0. Bits 31:12 read 0. Interrupt line i (i = 0..3) is high exactly while status bit i is 1.
- R7: A write to offset 0x10 whose bits 31:4 equal 0x4CE7395 loads data bits 1:0 into the semaphore.
- R8: A write to offset 0x10 with any other value in bits 31:4 leaves the semaphore unchanged. This includes keys that differ by one.
- R9: Offset 0x10 reads back the semaphore in bits 1:0. Bits 31:2, which include the key field and reserved bits 3:2, read 0.
- R10: Offsets 0x04, 0x08 and 0x0C read 0. Every other offset outside the map reads 0, and writes to those offsets change nothing.
- R11: If both ports write the semaphore with a valid key in the same cycle, the value from port A is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_wr | input | 1 | Port A write strobe |
| a_addr | input | 5 | Port A byte offset |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A read data (combinational) |
| b_wr | input | 1 | Port B write strobe |
| b_addr | input | 5 | Port B byte offset |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data (combinational) |
| irq_out | output | 4 | Interrupt lines, one per low flag |

## Verification
A write presented before a rising edge is visible one edge later. Read data and interrupt lines follow the state with no delay. The bench therefore drives every write at a falling edge and lets exactly one rising edge pass. It then samples the read data and interrupt lines at the following falling edge, after the address has settled. Expected flag and semaphore values come from a bit-mask model in the bench. That model is updated for each bus cycle, including same-cycle collisions between the two ports.

// File: rtl/ipc_mailbox_regs.sv
module ipc_mailbox_regs #(
  parameter int FLAG_N  = 12,
  parameter int IRQ_N   = 4,
  parameter int SEM_W   = 2,
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int KEY_LSB = 4,
  parameter logic [DW-KEY_LSB-1:0] KEY_VAL = 28'h4CE7395
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic [IRQ_N-1:0] irq_out
);
  localparam logic [AW-1:0] OFS_STAT = AW'(0);
  localparam logic [AW-1:0] OFS_SET  = AW'(4);
  localparam logic [AW-1:0] OFS_CLR  = AW'(8);
  localparam logic [AW-1:0] OFS_ACK  = AW'(12);
  localparam logic [AW-1:0] OFS_SEM  = AW'(16);

  logic [FLAG_N-1:0] flags;
  logic [SEM_W-1:0]  sem;

  logic a_set, b_set, a_clr, b_clr, a_key, b_key;
  assign a_set = a_wr && (a_addr == OFS_SET);
  assign b_set = b_wr && (b_addr == OFS_SET);
  assign a_clr = a_wr && (a_addr == OFS_CLR || a_addr == OFS_ACK);
  assign b_clr = b_wr && (b_addr == OFS_CLR || b_addr == OFS_ACK);
  assign a_key = a_wr && (a_addr == OFS_SEM) && (a_wdata[DW-1:KEY_LSB] == KEY_VAL);
  assign b_key = b_wr && (b_addr == OFS_SEM) && (b_wdata[DW-1:KEY_LSB] == KEY_VAL);

  logic [FLAG_N-1:0] set_m, clr_m;
  assign set_m = (a_set ? a_wdata[FLAG_N-1:0] : '0) | (b_set ? b_wdata[FLAG_N-1:0] : '0);
  assign clr_m = (a_clr ? a_wdata[FLAG_N-1:0] : '0) | (b_clr ? b_wdata[FLAG_N-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags | set_m) & ~clr_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sem <= '0;
    else if (a_key) sem <= a_wdata[SEM_W-1:0];
    else if (b_key) sem <= b_wdata[SEM_W-1:0];
  end

  function automatic logic [DW-1:0] rd_mux(input logic [AW-1:0] ad,
                                           input logic [FLAG_N-1:0] f,
                                           input logic [SEM_W-1:0] s);
    case (ad)
      OFS_STAT: rd_mux = DW'(f);
      OFS_SEM:  rd_mux = DW'(s);
      default:  rd_mux = '0;
    endcase
  endfunction

  assign a_rdata = rd_mux(a_addr, flags, sem);
  assign b_rdata = rd_mux(b_addr, flags, sem);
  assign irq_out = flags[IRQ_N-1:0];
endmodule

// File: rtl/ipc_mailbox_regs_chk.sv
module ipc_mailbox_regs_chk #(
  parameter int FLAG_N  = 12,
  parameter int IRQ_N   = 4,
  parameter int SEM_W   = 2,
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int KEY_LSB = 4,
  parameter logic [DW-KEY_LSB-1:0] KEY_VAL = 28'h4CE7395
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_wr,
  input logic [AW-1:0]     a_addr,
  input logic [DW-1:0]     a_wdata,
  input logic              b_wr,
  input logic [AW-1:0]     b_addr,
  input logic [DW-1:0]     b_wdata,
  input logic [IRQ_N-1:0]  irq_out,
  input logic [FLAG_N-1:0] flags,
  input logic [SEM_W-1:0]  sem
);
  logic [FLAG_N-1:0] up_m, dn_m;
  logic a_semw, b_semw, a_ok, b_ok;
  assign up_m = ((a_wr && a_addr == AW'(4)) ? a_wdata[FLAG_N-1:0] : '0)
              | ((b_wr && b_addr == AW'(4)) ? b_wdata[FLAG_N-1:0] : '0);
  assign dn_m = ((a_wr && (a_addr == AW'(8) || a_addr == AW'(12))) ? a_wdata[FLAG_N-1:0] : '0)
              | ((b_wr && (b_addr == AW'(8) || b_addr == AW'(12))) ? b_wdata[FLAG_N-1:0] : '0);
  assign a_semw = a_wr && a_addr == AW'(16);
  assign b_semw = b_wr && b_addr == AW'(16);
  assign a_ok = a_semw && a_wdata[DW-1:KEY_LSB] == KEY_VAL;
  assign b_ok = b_semw && b_wdata[DW-1:KEY_LSB] == KEY_VAL;

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(up_m & ~dn_m) |=> ((flags & $past(up_m & ~dn_m)) == $past(up_m & ~dn_m)));
  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |dn_m |=> ((flags & $past(dn_m)) == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_wr || b_wr) |=> ($stable(flags) && $stable(sem)));
  // R8
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_ok && !b_ok) |=> $stable(sem));
  // R11
  good_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_ok |=> (sem == $past(a_wdata[SEM_W-1:0])));
  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq_out & $past(irq_out) & ~$past(dn_m[IRQ_N-1:0])) == '0));
endmodule

bind ipc_mailbox_regs ipc_mailbox_regs_chk #(
  .FLAG_N(FLAG_N), .IRQ_N(IRQ_N), .SEM_W(SEM_W), .AW(AW), .DW(DW),
  .KEY_LSB(KEY_LSB), .KEY_VAL(KEY_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
  .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
  .irq_out(irq_out), .flags(flags), .sem(sem)
);

// File: tb/ipc_mailbox_regs_test.sv
`timescale 1ns/1ps
module ipc_mailbox_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_wr = 1'b0, b_wr = 1'b0;
  logic [4:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic [3:0] irq_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [11:0] mflags = '0;
  logic [1:0]  msem = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  localparam logic [31:0] KEYW = 32'h4CE7_3950;

  always #5 clk = ~clk;

  ipc_mailbox_regs uut (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic aw, input logic [4:0] aa, input logic [31:0] ad,
                     input logic bw, input logic [4:0] ba, input logic [31:0] bd);
    a_wr = aw; a_addr = aa; a_wdata = ad;
    b_wr = bw; b_addr = ba; b_wdata = bd;
    @(posedge clk);
    @(negedge clk);
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic rd_a(input logic [4:0] ad, output logic [31:0] v);
    a_addr = ad;
    #1 v = a_rdata;
  endtask

  task automatic rd_b(input logic [4:0] ad, output logic [31:0] v);
    b_addr = ad;
    #1 v = b_rdata;
  endtask

  function automatic logic [11:0] upm(input logic w, input logic [4:0] a, input logic [31:0] d);
    return (w && a == 5'h04) ? d[11:0] : 12'h0;
  endfunction
  function automatic logic [11:0] dnm(input logic w, input logic [4:0] a, input logic [31:0] d);
    return (w && (a == 5'h08 || a == 5'h0C)) ? d[11:0] : 12'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_a(5'h00, v); chk("R1 status", v, 32'h0);
    rd_b(5'h10, v); chk("R1 sem", v, 32'h0);
    chk("R1 irq", {28'h0, irq_out}, 32'h0);

    // R2 R3 R4 R6: walk each flag
    for (int i = 0; i < 12; i++) begin
      cyc(1'b1, 5'h04, 32'h1 << i, 1'b0, 5'h00, 32'h0);
      rd_b(5'h00, v); chk("R2 set bit", v, 32'h1 << i);
      chk("R6 irq follows", {28'h0, irq_out}, (32'h1 << i) & 32'hF);
      if (i % 2 == 0) begin
        cyc(1'b0, 5'h00, 32'h0, 1'b1, 5'h0C, 32'h1 << i);
        rd_a(5'h00, v); chk("R4 ack clears", v, 32'h0);
      end else begin
        cyc(1'b0, 5'h00, 32'h0, 1'b1, 5'h08, 32'h1 << i);
        rd_a(5'h00, v); chk("R3 clear clears", v, 32'h0);
      end
      chk("R6 irq low", {28'h0, irq_out}, 32'h0);
    end

    // R6 upper bits read zero
    cyc(1'b1, 5'h04, 32'hFFFF_FFFF, 1'b0, 5'h00, 32'h0);
    rd_a(5'h00, v); chk("R6 width", v, 32'h0000_0FFF);
    chk("R6 irq all", {28'h0, irq_out}, 32'hF);
    // R2 zero bits have no effect on set; R3 zero bits keep flags
    cyc(1'b1, 5'h04, 32'h0, 1'b1, 5'h08, 32'h0);
    rd_a(5'h00, v); chk("R2 zero write", v, 32'h0000_0FFF);
    cyc(1'b1, 5'h08, 32'h0000_0F0F, 1'b0, 5'h00, 32'h0);
    rd_a(5'h00, v); chk("R3 partial clear", v, 32'h0000_00F0);
    cyc(1'b1, 5'h0C, 32'hFFF, 1'b0, 5'h00, 32'h0);

    // R5 simultaneous set and clear/ack on each bit
    for (int i = 0; i < 12; i++) begin
      cyc(1'b1, 5'h04, 32'hFFF, 1'b1, (i % 2 == 0) ? 5'h08 : 5'h0C, 32'h1 << i);
      rd_a(5'h00, v); chk("R5 clear wins", v, 32'hFFF & ~(32'h1 << i));
      cyc(1'b1, 5'h0C, 32'hFFF, 1'b0, 5'h00, 32'h0);
    end
    // R5 reverse ports
    cyc(1'b1, 5'h0C, 32'h5, 1'b1, 5'h04, 32'h7);
    rd_a(5'h00, v); chk("R5 port swap", v, 32'h2);
    cyc(1'b1, 5'h08, 32'hFFF, 1'b0, 5'h00, 32'h0);

    // R2 R3 R4 R5 pseudo-random two-port sweep against the model
    mflags = '0;
    for (int n = 0; n < 200; n++) begin
      logic [4:0] aa, ba;
      logic [31:0] ad, bd;
      logic aw, bw;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      aa = {1'b0, lfsr[1:0], 2'b00}; ba = {1'b0, lfsr[3:2], 2'b00};
      aw = lfsr[4]; bw = lfsr[5];
      ad = {20'h0, lfsr[17:6]}; bd = {20'h0, lfsr[29:18]};
      mflags = (mflags | upm(aw, aa, ad) | upm(bw, ba, bd)) & ~(dnm(aw, aa, ad) | dnm(bw, ba, bd));
      cyc(aw, aa, ad, bw, ba, bd);
      rd_b(5'h00, v); chk("R5 sweep status", v, {20'h0, mflags});
      chk("R6 sweep irq", {28'h0, irq_out}, {28'h0, mflags[3:0]});
    end
    cyc(1'b1, 5'h08, 32'hFFF, 1'b0, 5'h00, 32'h0);

    // R7 R8 R9 semaphore key handling
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, 5'h10, KEYW | s, 1'b0, 5'h00, 32'h0);
      msem = 2'(s);
      rd_a(5'h10, v); chk("R7 good key", v, {30'h0, msem});
      cyc(1'b0, 5'h00, 32'h0, 1'b1, 5'h10, (KEYW + 32'h10) | (s ^ 3));
      rd_a(5'h10, v); chk("R8 key plus one", v, {30'h0, msem});
      cyc(1'b1, 5'h10, (KEYW - 32'h10) | (s ^ 1), 1'b0, 5'h00, 32'h0);
      rd_b(5'h10, v); chk("R8 key minus one", v, {30'h0, msem});
      cyc(1'b1, 5'h10, KEYW | 32'hC | s, 1'b0, 5'h00, 32'h0);
      rd_b(5'h10, v); chk("R9 reserved and key read zero", v, {30'h0, 2'(s)});
    end
    cyc(1'b0, 5'h00, 32'h0, 1'b1, 5'h10, 32'h0000_0002);
    rd_a(5'h10, v); chk("R8 zero key", v, 32'h3);

    // R11 both ports write valid keys
    cyc(1'b1, 5'h10, KEYW | 32'h1, 1'b1, 5'h10, KEYW | 32'h2);
    rd_a(5'h10, v); chk("R11 port A priority", v, 32'h1);

    // R10 strobe registers and unmapped offsets
    cyc(1'b1, 5'h04, 32'hA5A, 1'b0, 5'h00, 32'h0);
    rd_a(5'h04, v); chk("R10 set reads 0", v, 32'h0);
    rd_a(5'h08, v); chk("R10 clear reads 0", v, 32'h0);
    rd_b(5'h0C, v); chk("R10 ack reads 0", v, 32'h0);
    rd_a(5'h14, v); chk("R10 unmapped reads 0", v, 32'h0);
    rd_b(5'h02, v); chk("R10 unaligned reads 0", v, 32'h0);
    cyc(1'b1, 5'h14, 32'hFFFF_FFFF, 1'b1, 5'h09, 32'hFFF);
    rd_a(5'h00, v); chk("R10 unmapped write status", v, 32'hA5A);
    rd_b(5'h10, v); chk("R10 unmapped write sem", v, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule